// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block sits between a UART's serial deserializer and its host register interface. Each byte the deserializer delivers is stored in a 16-entry first-in first-out queue. A host read of the receive buffer address pops the oldest byte. The block keeps the receive-side line status flags: data ready, break seen and overrun. It compares the fill level against a trigger threshold that software selects, and it runs a character-timeout counter. That counter raises a pending flag when bytes sit unread for four character times. The block also decodes writes to the FIFO control register. Those writes can enable queueing, pick the trigger threshold, flush the receive queue, or request a flush of the transmit queue, which is sent out as a one-cycle strobe.

When queueing is disabled, the block behaves as a classic single-byte holding register. A new byte replaces the old one, and it flags an overrun if the old byte was never read. Interrupt arbitration and serial framing are done elsewhere. The character time is an input, given in clock cycles.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: In queue mode (FIFO control bit 0 set), up to 16 bytes are held, and receive buffer reads return them in arrival order one cycle after the read strobe.
- R2: FIFO control bits 7:6 choose the trigger threshold: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. In queue mode `trig_hit` is high exactly when the fill level is at or above the threshold. In holding-register mode it follows data ready.
- R3: A byte that arrives while 16 bytes are stored is dropped and the stored bytes stay unchanged. The overrun flag is set, and a line status read clears it.
- R4: A read of an empty queue returns 0x00. Data ready and break are cleared by the read that leaves the fill level at zero.
- R5: Each received byte, and each read that leaves bytes behind, restarts a window of 4 × `char_time` cycles. When the window ends, `tmo_pend` rises only if the queue is not empty, exactly 4 × `char_time` clock edges after the restarting edge.
- R6: Any receive buffer read clears `tmo_pend`.
- R7: A FIFO control write with bit 1 set empties the receive queue, clears data ready and `tmo_pend`, and stops the timeout window.
- R8: A FIFO control write with bit 2 set produces a one-cycle `tx_fifo_clr` pulse.
- R9: A FIFO control write that changes bit 0 performs both the receive flush and the transmit clear pulse, whatever bits 1 and 2 hold.
- R10: Only FIFO control bits 7, 6, 3 and 0 are kept (mask 0xC9), so bits 1 and 2 never read back as set. Writing the value already held has no effect at all.
- R11: In holding-register mode each new byte replaces the held byte and sets overrun if data ready was already set. A read returns the held byte and clears data ready.
- R12: After reset the control value, fill level, data ready, break, overrun and `tmo_pend` are all zero. A byte delivered with `rx_brk` high sets the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Deserializer delivers a byte this cycle |
| rx_byte | input | DW | Received byte |
| rx_brk | input | 1 | Delivered byte was a break condition |
| rbr_rd | input | 1 | Host reads the receive buffer |
| lsr_rd | input | 1 | Host reads line status (clears overrun and break) |
| fcr_wr | input | 1 | Host writes the FIFO control register |
| fcr_wdata | input | 8 | FIFO control write value |
| char_time | input | CTW | One character time in clock cycles (at least 1) |
| rbr_data | output | DW | Byte returned by the last receive buffer read |
| lsr_dr | output | 1 | Data ready |
| lsr_oe | output | 1 | Overrun |
| lsr_bi | output | 1 | Break seen |
| rx_level | output | CW | Current fill level |
| trig_hit | output | 1 | Fill level at or above the trigger threshold |
| tmo_pend | output | 1 | Character timeout pending |
| fcr_state | output | 8 | Retained FIFO control bits |
| fifo_mode | output | 1 | Queue mode active |
| tx_fifo_clr | output | 1 | One-cycle transmit queue clear strobe |

## Verification
The bench overfills the queue, then drains all sixteen bytes against a scoreboard. A design that let the dropped byte overwrite an entry would return the wrong byte in one slot. It probes the timeout edge to the exact cycle, both with data waiting and with the queue already emptied. An off-by-one counter, or a timer that ignores the fill level, fails there. It toggles the enable bit with bits 1 and 2 clear, rewrites the control value unchanged, and writes only the flush bits. A design that skipped the forced flush, acted on repeated writes, or let the reset bits stick shows a wrong level, pulse or read-back value. Holding-register mode is checked for overwrite with overrun and for break clearing on read.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  localparam int FCR_EN_BIT   = 0;
  localparam int FCR_RXCLR    = 1;
  localparam int FCR_TXCLR    = 2;
  localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_FOUR     = 2'b01,
    TRIG_EIGHT    = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_e;

  function automatic int trig_level(input trig_sel_e sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_fcr_reg.sv
module rxf_fcr_reg
  import uart_rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] fcr_q,
  output logic       rx_flush,
  output logic       tx_clr_q
);
  logic       changed;
  logic       en_toggle;
  logic [7:0] eff;

  always_comb begin
    changed   = wr && (wdata != fcr_q);
    en_toggle = wdata[FCR_EN_BIT] ^ fcr_q[FCR_EN_BIT];
    eff       = wdata;
    if (en_toggle) begin
      eff[FCR_RXCLR] = 1'b1;
      eff[FCR_TXCLR] = 1'b1;
    end
    rx_flush  = changed && eff[FCR_RXCLR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcr_q    <= '0;
      tx_clr_q <= 1'b0;
    end else begin
      tx_clr_q <= changed && eff[FCR_TXCLR];
      if (changed) fcr_q <= eff & FCR_KEEP_MASK;
    end
  end

  p_same_value_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata == fcr_q) |=> ($stable(fcr_q) && !tx_clr_q));

  p_toggle_forces_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && (wdata[FCR_EN_BIT] != fcr_q[FCR_EN_BIT])) |=> tx_clr_q);

  p_reset_bits_gone_r10: assert property (@(posedge clk) disable iff (rst)
    wr |=> (fcr_q[FCR_RXCLR] == 1'b0 && fcr_q[FCR_TXCLR] == 1'b0));
endmodule

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_full_keeps_slots_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !flush) |=> $stable(wr_ptr));
endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout #(
  parameter int CTW  = 16,
  localparam int LW  = CTW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stop,
  input  logic           restart,
  input  logic [CTW-1:0] char_time,
  input  logic           data_present,
  input  logic           clear_pend,
  output logic           pend
);
  logic [LW-1:0] cnt;
  logic          armed;
  logic          expire;

  assign expire = armed && !restart && (cnt <= LW'(1));

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cnt   <= '0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (restart) begin
        cnt   <= {char_time, 2'b00};
        armed <= 1'b1;
      end else if (expire) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (armed) begin
        cnt   <= cnt - LW'(1);
      end
      if (clear_pend)                  pend <= 1'b0;
      else if (expire && data_present) pend <= 1'b1;
    end
  end

  p_stop_quiets_r7: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!pend && !armed));
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CTW   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_byte,
  input  logic           rx_brk,
  input  logic           rbr_rd,
  input  logic           lsr_rd,
  input  logic           fcr_wr,
  input  logic [7:0]     fcr_wdata,
  input  logic [CTW-1:0] char_time,
  output logic [DW-1:0]  rbr_data,
  output logic           lsr_dr,
  output logic           lsr_oe,
  output logic           lsr_bi,
  output logic [CW-1:0]  rx_level,
  output logic           trig_hit,
  output logic           tmo_pend,
  output logic [7:0]     fcr_state,
  output logic           fifo_mode,
  output logic           tx_fifo_clr
);
  logic          rx_flush;
  logic          q_full, q_empty;
  logic [DW-1:0] q_rdata;
  logic [DW-1:0] hold_q;
  logic          push, pop, last_pop, bytes_left, restart;

  rxf_fcr_reg u_fcr (
    .clk      (clk),
    .rst      (rst),
    .wr       (fcr_wr),
    .wdata    (fcr_wdata),
    .fcr_q    (fcr_state),
    .rx_flush (rx_flush),
    .tx_clr_q (tx_fifo_clr)
  );

  assign fifo_mode = fcr_state[FCR_EN_BIT];
  assign push      = fifo_mode && rx_valid;
  assign pop       = fifo_mode && rbr_rd;

  rxf_storage #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush),
    .push  (push),
    .pop   (pop),
    .wdata (rx_byte),
    .rdata (q_rdata),
    .count (rx_level),
    .full  (q_full),
    .empty (q_empty)
  );

  assign bytes_left = !q_empty && ((rx_level != CW'(1)) || rx_valid);
  assign last_pop   = pop && !bytes_left;
  assign restart    = fifo_mode && (rx_valid || (rbr_rd && bytes_left));

  rxf_timeout #(.CTW(CTW)) u_tmo (
    .clk          (clk),
    .rst          (rst),
    .stop         (rx_flush),
    .restart      (restart),
    .char_time    (char_time),
    .data_present (!q_empty),
    .clear_pend   (rbr_rd),
    .pend         (tmo_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rbr_data <= '0;
      hold_q   <= '0;
      lsr_dr   <= 1'b0;
      lsr_oe   <= 1'b0;
      lsr_bi   <= 1'b0;
    end else begin
      if (rbr_rd)
        rbr_data <= fifo_mode ? (q_empty ? '0 : q_rdata) : hold_q;
      if (lsr_rd) begin
        lsr_oe <= 1'b0;
        lsr_bi <= 1'b0;
      end
      if (fifo_mode) begin
        if (last_pop) begin
          lsr_dr <= 1'b0;
          lsr_bi <= 1'b0;
        end
        if (rx_valid) begin
          lsr_dr <= 1'b1;
          if (rx_brk) lsr_bi <= 1'b1;
          if (q_full) lsr_oe <= 1'b1;
        end
      end else begin
        if (rbr_rd) begin
          lsr_dr <= 1'b0;
          lsr_bi <= 1'b0;
        end
        if (rx_valid) begin
          hold_q <= rx_byte;
          lsr_dr <= 1'b1;
          if (rx_brk) lsr_bi <= 1'b1;
          if (lsr_dr) lsr_oe <= 1'b1;
        end
      end
      if (rx_flush) begin
        lsr_dr <= 1'b0;
        lsr_bi <= 1'b0;
      end
    end
  end

  always_comb begin
    if (fifo_mode)
      trig_hit = (int'(rx_level) >= trig_level(trig_sel_e'(fcr_state[7:6])));
    else
      trig_hit = lsr_dr;
  end

  p_pend_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
    tmo_pend |-> (rx_level != '0));

  p_read_clears_pend_r6: assert property (@(posedge clk) disable iff (rst)
    rbr_rd |=> !tmo_pend);

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && rbr_rd && q_empty && !rx_flush) |=> (rbr_data == '0));

  p_overrun_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && rx_valid && q_full && !rbr_rd && !rx_flush)
      |=> (lsr_oe && rx_level == CW'(DEPTH)));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (rx_level == '0 && !lsr_dr && !tmo_pend));

  p_hold_overrun_r11: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && !fcr_wr && rx_valid && lsr_dr) |=> lsr_oe);
endmodule

// File: tb/test_uart_rx_fifo_ctl.sv
module test_uart_rx_fifo_ctl;
  localparam int DEPTH = 16;
  localparam int CT    = 5;
  localparam int L     = 4 * CT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_brk = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0, fcr_wr = 1'b0;
  logic [7:0]  rx_byte = '0, fcr_wdata = '0;
  logic [15:0] char_time = 16'(CT);
  logic [7:0]  rbr_data, fcr_state;
  logic        lsr_dr, lsr_oe, lsr_bi, trig_hit, tmo_pend, fifo_mode, tx_fifo_clr;
  logic [4:0]  rx_level;

  int checks = 0, errors = 0;
  logic [7:0] model_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] m_hold = '0;
  bit   m_fifo = 0;
  logic rd_was = 1'b0;
  bit   done = 0;

  always #10 clk = ~clk;

  uart_rx_fifo_ctl i_uart_rx_fifo_ctl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_brk(rx_brk),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .char_time(char_time), .rbr_data(rbr_data), .lsr_dr(lsr_dr), .lsr_oe(lsr_oe),
    .lsr_bi(lsr_bi), .rx_level(rx_level), .trig_hit(trig_hit), .tmo_pend(tmo_pend),
    .fcr_state(fcr_state), .fifo_mode(fifo_mode), .tx_fifo_clr(tx_fifo_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic brk = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_brk = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_brk = 1'b0;
    if (m_fifo) begin
      if (model_q.size() < DEPTH) model_q.push_back(b);
    end else m_hold = b;
  endtask

  task automatic read_rbr();
    logic [7:0] e;
    if (m_fifo) e = (model_q.size() > 0) ? model_q.pop_front() : 8'h00;
    else        e = m_hold;
    exp_q.push_back(e);
    @(negedge clk); rbr_rd = 1'b1;
    @(negedge clk); rbr_rd = 1'b0;
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    @(negedge clk); fcr_wr = 1'b1; fcr_wdata = v;
    @(negedge clk); fcr_wr = 1'b0;
  endtask

  task automatic read_lsr();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
  endtask

  // scoreboard monitor: compares each read result one edge after the strobe
  always @(posedge clk) rd_was <= rbr_rd;
  initial begin
    forever begin
      @(negedge clk);
      if (rd_was) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected read", int'(rbr_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rbr_data == e, "R1/R4 read data", int'(rbr_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(fcr_state == 8'h00, "R12 fcr reset", fcr_state, 0);
    chk(rx_level == 0, "R12 level reset", rx_level, 0);
    chk({lsr_dr, lsr_oe, lsr_bi, tmo_pend} == 4'b0, "R12 status reset",
        {lsr_dr, lsr_oe, lsr_bi, tmo_pend}, 0);

    // R11 holding-register mode
    push(8'h11);
    chk(lsr_dr && !lsr_oe, "R11 first byte ready", {lsr_dr, lsr_oe}, 2'b10);
    chk(trig_hit, "R2 hold mode trig follows ready", trig_hit, 1);
    push(8'h22);
    chk(lsr_oe, "R11 overwrite sets overrun", lsr_oe, 1);
    read_rbr();
    chk(!lsr_dr, "R11 read clears ready", lsr_dr, 0);
    read_lsr();
    chk(!lsr_oe, "R3 line status read clears overrun", lsr_oe, 0);
    push(8'h00, 1'b1);
    chk(lsr_bi, "R12 break sets flag", lsr_bi, 1);
    read_rbr();
    chk(!lsr_bi && !lsr_dr, "R11 read clears break", {lsr_bi, lsr_dr}, 0);

    // R9 enable toggle forces transmit clear
    wr_fcr(8'h01); m_fifo = 1;
    chk(tx_fifo_clr, "R9 toggle pulses tx clear", tx_fifo_clr, 1);
    chk(fcr_state == 8'h01 && fifo_mode, "R10 enable kept", fcr_state, 8'h01);
    @(negedge clk);
    chk(!tx_fifo_clr, "R8 pulse lasts one cycle", tx_fifo_clr, 0);

    // R1 order, R4 empty read
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk(rx_level == 3 && trig_hit, "R2 level 1 trigger", rx_level, 3);
    read_rbr(); read_rbr();
    chk(lsr_dr, "R4 ready stays while bytes remain", lsr_dr, 1);
    read_rbr();
    chk(!lsr_dr, "R4 last read clears ready", lsr_dr, 0);
    read_rbr();

    // R2 threshold 14
    wr_fcr(8'hC1);
    chk(!tx_fifo_clr && fcr_state == 8'hC1, "R10 no toggle no pulse", fcr_state, 8'hC1);
    for (int i = 0; i < 13; i++) push(8'h40 + 8'(i));
    chk(rx_level == 13 && !trig_hit, "R2 below 14", rx_level, 13);
    push(8'h4D);
    chk(trig_hit, "R2 reaches 14", trig_hit, 1);
    wr_fcr(8'h41);
    chk(rx_level == 14 && trig_hit, "R2 level 4 no flush", rx_level, 14);

    // R3 overrun keeps contents
    push(8'h4E); push(8'h4F);
    chk(rx_level == 16 && !lsr_oe, "R1 full at 16", rx_level, 16);
    push(8'hEE);
    chk(rx_level == 16 && lsr_oe, "R3 overrun flagged, level kept", {lsr_oe, rx_level}, {1'b1, 5'd16});
    for (int i = 0; i < 16; i++) read_rbr();
    chk(rx_level == 0, "R3 drained", rx_level, 0);
    read_lsr();
    chk(!lsr_oe, "R3 overrun cleared", lsr_oe, 0);

    // R5/R6 timeout
    push(8'h77);
    repeat (L - 1) @(negedge clk);
    chk(!tmo_pend, "R5 not before window", tmo_pend, 0);
    @(negedge clk);
    chk(tmo_pend, "R5 at window end", tmo_pend, 1);
    read_rbr();
    chk(!tmo_pend, "R6 read clears pending", tmo_pend, 0);
    push(8'h78);
    read_rbr();
    repeat (L + 4) @(negedge clk);
    chk(!tmo_pend, "R5 empty queue no pending", tmo_pend, 0);

    // R7 receive flush
    push(8'h01); push(8'h02); push(8'h03);
    repeat (L + 2) @(negedge clk);
    chk(tmo_pend, "R5 pending with data", tmo_pend, 1);
    wr_fcr(8'h43); model_q.delete();
    chk(rx_level == 0 && !lsr_dr && !tmo_pend, "R7 flush empties", {rx_level, lsr_dr, tmo_pend}, 0);
    chk(fcr_state == 8'h41 && !tx_fifo_clr, "R10 reset bit not kept", fcr_state, 8'h41);
    repeat (L + 4) @(negedge clk);
    chk(!tmo_pend, "R7 timer stopped", tmo_pend, 0);

    // R8 transmit clear only
    push(8'h91); push(8'h92);
    wr_fcr(8'h45);
    chk(tx_fifo_clr && rx_level == 2, "R8 tx clear keeps rx", {tx_fifo_clr, rx_level}, {1'b1, 5'd2});
    chk(fcr_state == 8'h41, "R10 bit 2 not kept", fcr_state, 8'h41);

    // R10 same value and bit 3
    wr_fcr(8'h41);
    chk(!tx_fifo_clr && rx_level == 2, "R10 same value no effect", {tx_fifo_clr, rx_level}, 2);
    wr_fcr(8'hCF);
    chk(fcr_state == 8'hC9 && rx_level == 0, "R10 mask 0xC9", fcr_state, 8'hC9);
    model_q.delete();

    // R9 disable flushes
    push(8'h33);
    wr_fcr(8'h00); m_fifo = 0; model_q.delete();
    chk(rx_level == 0 && tx_fifo_clr && !lsr_dr, "R9 disable flushes", {rx_level, tx_fifo_clr}, 6'b000001);

    // R4/R12 break in queue mode
    wr_fcr(8'h01); m_fifo = 1;
    push(8'h00, 1'b1); push(8'h55);
    chk(lsr_bi, "R12 break in queue mode", lsr_bi, 1);
    read_rbr();
    chk(lsr_bi, "R4 break held while bytes remain", lsr_bi, 1);
    read_rbr();
    chk(!lsr_bi && !lsr_dr, "R4 break and ready clear at zero", {lsr_bi, lsr_dr}, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all reads compared", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule